// File: doc/BRIEF.md
# Translation Lookaside Cache with Access Rights Check

This block sits between a requester that issues virtual page numbers and an external page table walker. It holds a small, fully associative set of recent translations. Every accepted request is compared against all stored entries in a single cycle. On a match, the stored access rights are checked against the kind of access. The block then answers either with the physical frame number or with a protection fault. It never consults the walker for such a request.

When no entry matches, the block stalls the requester by dropping its ready signal. It then asks the walker for the mapping. If the walker returns a valid mapping, the block writes it into the array, evicting an entry if necessary, and answers the stalled request. If the walker reports a page fault, the block passes that fault on and stores nothing. A flush input invalidates the whole array in one cycle. The entry count is a parameter and is meant to lie between 8 and 64.

Top module: `tlb_xlate`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. A request that matches a valid entry gets its answer with `rsp_valid` high in the very next cycle, and `req_ready` stays high, so matching requests can be accepted on consecutive cycles.
- R2: A matching request whose access is permitted returns the stored frame on `rsp_pfn`, with both fault flags low, and `walk_req_valid` stays low.
- R3: Access kinds are encoded as 0 = read (rights bit 0), 1 = write (rights bit 1), 2 = execute (rights bit 2), and 3 = never permitted. A denied access answers with `rsp_prot_fault` = 1, `rsp_page_fault` = 0 and `rsp_pfn` = 0.
- R4: A request that matches no entry raises `walk_req_valid`, with `walk_req_vpn` equal to the requested page, in the cycle after acceptance. Both hold steady until the edge where `walk_rsp_valid` is high. `req_ready` is low over that same span, and the answer appears in the cycle after the walker's response.
- R5: A successful walker response is stored, and the answer applies the R3 check to the rights the walker returned. A later request to the same page matches without a walk.
- R6: A walker response with `walk_rsp_fault` high answers with `rsp_page_fault` = 1, `rsp_prot_fault` = 0 and `rsp_pfn` = 0. Nothing is stored, so the same page misses again.
- R7: A new mapping goes to the lowest-numbered invalid entry. When all entries are valid, it goes to the entry named by a rotating pointer. That pointer starts at 0 after reset and advances by one, wrapping, on each such replacement.
- R8: A flush invalidates every entry on the edge where it is high, so later requests miss. A request accepted on that same edge still sees the contents from before the flush.
- R9: If a flush coincides with a successful walker response, the answer is still delivered, but the mapping is not kept and the rotating pointer does not move.
- R10: After reset, no entry is valid, `req_ready` is high, and `rsp_valid` and `walk_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Answer valid this cycle |
| rsp_pfn | output | PFN_W | Physical frame number, zero on any fault |
| rsp_prot_fault | output | 1 | Access denied by the stored rights |
| rsp_page_fault | output | 1 | Walker found no mapping |
| walk_req_valid | output | 1 | Mapping requested from the walker |
| walk_req_vpn | output | VPN_W | Page the walker should look up |
| walk_rsp_valid | input | 1 | Walker result present |
| walk_rsp_pfn | input | PFN_W | Frame returned by the walker |
| walk_rsp_perm | input | 3 | Rights returned by the walker (bit 0 read, 1 write, 2 execute) |
| walk_rsp_fault | input | 1 | Walker reports no mapping |

## Verification
A flush can fall on the same edge as either of the other two events that touch the array: a lookup that matches, or the installation of a walker result. The bench provokes the first case by raising flush on the acceptance edge of a request to a cached page. It provokes the second by having its walker model raise flush exactly when it returns a mapping. Random traffic with occasional flushes adds further coincidences. In each case, the behavioural model expects the pre-flush answer, or a delivered answer with nothing stored. A follow-up request to the same page then has to miss, which is judged on `walk_req_valid` and `req_ready`.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [1:0]       req_kind,
  output logic             rsp_valid,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_prot_fault,
  output logic             rsp_page_fault,
  output logic             walk_req_valid,
  output logic [VPN_W-1:0] walk_req_vpn,
  input  logic             walk_rsp_valid,
  input  logic [PFN_W-1:0] walk_rsp_pfn,
  input  logic [2:0]       walk_rsp_perm,
  input  logic             walk_rsp_fault
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_v;
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
  logic [2:0]         ent_perm [ENTRIES];

  logic               busy;
  logic [VPN_W-1:0]   walk_vpn;
  logic [1:0]         walk_kind;
  logic [IDX_W-1:0]   rr;

  logic [ENTRIES-1:0] hit_vec;
  logic [PFN_W-1:0]   hit_pfn;
  logic [2:0]         hit_perm;
  logic [IDX_W-1:0]   vic;
  logic               any_free;

  function automatic logic permitted(input logic [2:0] perm, input logic [1:0] kind);
    case (kind)
      2'd0:    return perm[0];
      2'd1:    return perm[1];
      2'd2:    return perm[2];
      default: return 1'b0;
    endcase
  endfunction

  assign req_ready      = !busy;
  assign walk_req_valid = busy;
  assign walk_req_vpn   = walk_vpn;

  wire accept  = req_valid && !busy;
  wire hit     = |hit_vec;
  wire hit_ok  = permitted(hit_perm, req_kind);
  wire fill    = busy && walk_rsp_valid;
  wire install = fill && !walk_rsp_fault;
  wire fill_ok = permitted(walk_rsp_perm, walk_kind);

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = ent_v[g] && (ent_vpn[g] == req_vpn);
    end
  endgenerate

  always_comb begin
    hit_pfn  = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_pfn  = hit_pfn  | (ent_pfn[i]  & {PFN_W{hit_vec[i]}});
      hit_perm = hit_perm | (ent_perm[i] & {3{hit_vec[i]}});
    end
  end

  always_comb begin
    vic      = rr;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_v[i]) begin
        vic      = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy           <= 1'b0;
      walk_vpn       <= '0;
      walk_kind      <= '0;
      rsp_valid      <= 1'b0;
      rsp_pfn        <= '0;
      rsp_prot_fault <= 1'b0;
      rsp_page_fault <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (hit) begin
          rsp_valid      <= 1'b1;
          rsp_pfn        <= hit_ok ? hit_pfn : '0;
          rsp_prot_fault <= !hit_ok;
          rsp_page_fault <= 1'b0;
        end else begin
          busy      <= 1'b1;
          walk_vpn  <= req_vpn;
          walk_kind <= req_kind;
        end
      end else if (fill) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        if (walk_rsp_fault) begin
          rsp_pfn        <= '0;
          rsp_prot_fault <= 1'b0;
          rsp_page_fault <= 1'b1;
        end else begin
          rsp_pfn        <= fill_ok ? walk_rsp_pfn : '0;
          rsp_prot_fault <= !fill_ok;
          rsp_page_fault <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v <= '0;
      rr    <= '0;
    end else if (flush) begin
      ent_v <= '0;
    end else if (install) begin
      ent_v[vic] <= 1'b1;
      if (!any_free)
        rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      ent_vpn[vic]  <= walk_vpn;
      ent_pfn[vic]  <= walk_rsp_pfn;
      ent_perm[vic] <= walk_rsp_perm;
    end
  end

  assert_hit_next_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (rsp_valid && req_ready));

  assert_no_walk_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> !walk_req_valid);

  assert_denied_zero_pfn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_prot_fault) |-> (rsp_pfn == '0 && !rsp_page_fault));

  assert_miss_walks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (walk_req_valid && !req_ready && walk_req_vpn == $past(req_vpn)));

  assert_walk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_vpn)));

  assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_page_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && walk_rsp_valid && walk_rsp_fault) |=>
      (rsp_valid && rsp_page_fault && !rsp_prot_fault && rsp_pfn == '0));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_v == '0));

  assert_flush_fill_answers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && walk_req_valid && walk_rsp_valid) |=> (rsp_valid && ent_v == '0 && $stable(rr)));

endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
  localparam int ENTRIES = 8;
  localparam int VPN_W   = 12;
  localparam int PFN_W   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_s = 1'b0, flush_w = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [1:0] req_kind = '0;
  logic rsp_valid, rsp_prot_fault, rsp_page_fault;
  logic [PFN_W-1:0] rsp_pfn;
  logic walk_req_valid;
  logic [VPN_W-1:0] walk_req_vpn;
  logic walk_rsp_valid = 1'b0;
  logic [PFN_W-1:0] walk_rsp_pfn = '0;
  logic [2:0] walk_rsp_perm = '0;
  logic walk_rsp_fault = 1'b0;

  wire flush = flush_s | flush_w;

  always #2 clk = ~clk;

  tlb_xlate #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_pfn(rsp_pfn), .rsp_prot_fault(rsp_prot_fault),
    .rsp_page_fault(rsp_page_fault),
    .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
    .walk_rsp_perm(walk_rsp_perm), .walk_rsp_fault(walk_rsp_fault));

  int vectors = 0, miscompares = 0;
  string phase = "R10";

  task automatic chk(string tag, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // page table seen by the walker
  function automatic logic pt_fault(int v);
    return (v % 16) == 15;
  endfunction
  function automatic int pt_pfn(int v);
    return (v * 37 + 11) % (1 << PFN_W);
  endfunction
  function automatic int pt_perm(int v);
    return (v ^ (v >> 3)) & 7;
  endfunction
  function automatic bit allowed(int perm, int kind);
    if (kind == 3) return 1'b0;
    return ((perm >> kind) & 1) == 1;
  endfunction

  // walker model
  int lat = 0, wcnt = 0;
  bit flush_on_rsp = 1'b0;
  always @(negedge clk) begin
    if (walk_rsp_valid) begin
      walk_rsp_valid = 1'b0;
      flush_w = 1'b0;
    end else if (walk_req_valid) begin
      if (wcnt >= lat) begin
        walk_rsp_valid = 1'b1;
        walk_rsp_fault = pt_fault(int'(walk_req_vpn));
        walk_rsp_pfn   = PFN_W'(pt_pfn(int'(walk_req_vpn)));
        walk_rsp_perm  = 3'(pt_perm(int'(walk_req_vpn)));
        if (flush_on_rsp) begin
          flush_w = 1'b1;
          flush_on_rsp = 1'b0;
        end
        wcnt = 0;
        lat = int'($urandom_range(0, 3));
      end else begin
        wcnt++;
      end
    end
  end

  // behavioural reference model
  int mv[ENTRIES], mvpn[ENTRIES], mpfn[ENTRIES], mperm[ENTRIES];
  int mrr = 0;
  bit m_busy = 0, m_rsp_v = 0, m_pf = 0, m_prot = 0;
  int m_wvpn = 0, m_wkind = 0, m_pfn = 0;
  string m_tag = "R2";

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mv[i]) mv[i] = 0;
      mrr = 0; m_busy = 0; m_rsp_v = 0;
    end else begin
      bit fl, wv, wf;
      int rv, rk, wp, wperm;
      fl = flush; wv = walk_rsp_valid; wf = walk_rsp_fault;
      rv = int'(req_vpn); rk = int'(req_kind);
      wp = int'(walk_rsp_pfn); wperm = int'(walk_rsp_perm);
      m_rsp_v = 0;
      if (!m_busy && req_valid) begin
        int h;
        h = -1;
        for (int i = 0; i < ENTRIES; i++) if (mv[i] != 0 && mvpn[i] == rv) h = i;
        if (h >= 0) begin
          m_rsp_v = 1; m_pf = 0;
          m_prot = !allowed(mperm[h], rk);
          m_pfn = m_prot ? 0 : mpfn[h];
          m_tag = m_prot ? "R3" : "R2";
        end else begin
          m_busy = 1; m_wvpn = rv; m_wkind = rk;
        end
      end else if (m_busy && wv) begin
        m_busy = 0; m_rsp_v = 1;
        if (wf) begin
          m_pf = 1; m_prot = 0; m_pfn = 0; m_tag = "R6";
        end else begin
          int vi;
          bit freef;
          m_pf = 0;
          m_prot = !allowed(wperm, m_wkind);
          m_pfn = m_prot ? 0 : wp;
          m_tag = fl ? "R9" : "R5";
          vi = mrr; freef = 0;
          for (int i = ENTRIES - 1; i >= 0; i--) if (mv[i] == 0) begin vi = i; freef = 1; end
          if (!fl) begin
            mv[vi] = 1; mvpn[vi] = m_wvpn; mpfn[vi] = wp; mperm[vi] = wperm;
            if (!freef) mrr = (mrr + 1) % ENTRIES;
          end
        end
      end
      if (fl) foreach (mv[i]) mv[i] = 0;
    end
    #1;
    if (rst_n) begin
      chk({"R4/", phase}, "req_ready", longint'(req_ready), longint'(!m_busy));
      chk({"R4/", phase}, "walk_req_valid", longint'(walk_req_valid), longint'(m_busy));
      if (m_busy) chk({"R4/", phase}, "walk_req_vpn", longint'(walk_req_vpn), longint'(m_wvpn));
      chk({"R1/", phase}, "rsp_valid", longint'(rsp_valid), longint'(m_rsp_v));
      if (m_rsp_v) begin
        chk({m_tag, "/", phase}, "rsp_pfn", longint'(rsp_pfn), longint'(m_pfn));
        chk({m_tag, "/", phase}, "rsp_page_fault", longint'(rsp_page_fault), longint'(m_pf));
        chk({m_tag, "/", phase}, "rsp_prot_fault", longint'(rsp_prot_fault), longint'(m_prot));
      end
    end
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue(int v, int k);
    req_valid = 1'b1;
    req_vpn = VPN_W'(v);
    req_kind = 2'(k);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    flush_s = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired in phase %s", phase);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "req_ready", longint'(req_ready), 1);
    chk("R10", "rsp_valid", longint'(rsp_valid), 0);
    chk("R10", "walk_req_valid", longint'(walk_req_valid), 0);

    phase = "R5";
    for (int v = 1; v <= 5; v++) issue(v, 0);
    idle(4);
    phase = "R1";
    for (int v = 1; v <= 5; v++) issue(v, 0);
    for (int v = 5; v >= 1; v--) issue(v, v % 3);
    idle(2);

    phase = "R3";
    for (int k = 0; k < 4; k++) begin
      issue(2, k);
      issue(4, k);
    end
    idle(2);

    phase = "R6";
    issue(15, 0);
    idle(3);
    issue(15, 0);
    issue(31, 1);
    idle(3);

    phase = "R7";
    for (int v = 6; v <= 12; v++) issue(v, 0);
    for (int v = 1; v <= 12; v++) issue(v, 0);
    idle(3);

    phase = "R8";
    flush_s = 1'b1;
    issue(12, 0);
    issue(12, 0);
    idle(3);
    flush_s = 1'b1;
    @(negedge clk);
    flush_s = 1'b0;
    issue(12, 0);
    idle(3);

    phase = "R9";
    flush_on_rsp = 1'b1;
    issue(40, 0);
    idle(3);
    issue(40, 0);
    issue(40, 0);
    idle(3);

    phase = "MIX";
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 39) == 0) flush_s = 1'b1;
      issue(int'($urandom_range(0, 19)), int'($urandom_range(0, 3)));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(6);
    finish_run();
  end
endmodule